// File: doc/BRIEF.md
# Byte-Wide Host Window Bridge with Pointer Port

The bridge is a byte-wide slave on a host bus. It gives the host two ways to reach a 15-bit internal address space. In flat mode every host address except offset zero becomes the same internal address, so the host needs a 32 KiB window. In windowed mode the host decodes only four byte locations. These are a control register, the high and low bytes of an internal pointer, and a data port. Each data port access is sent to the internal space at the pointer. If stepping is enabled, the pointer then moves forward by one.

The control register is always at host offset zero. In it, bit 0 selects windowed mode, bit 1 enables pointer stepping, bit 4 is a ping-block flag exported to the rest of the chip, and bit 7 starts a soft reset. A soft reset clears the other control bits and the pointer. While it is in progress, bit 7 reads as 1 for a parameterised number of cycles. Internal accesses are combinational strobes with the read data returned in the same cycle. The host sees its read data one cycle after the request.

Top module: `regwin_bridge`

## Requirements
- R1: After rst_n is released, the control register reads 0x00, the pointer reads 0x0000 and cfg_ping_blk is 0.
- R2: The control register is reached at host offset 0 in both modes (in windowed mode, when host_addr[1:0] is 0). Only bits 0, 1 and 4 hold written values; the other bits, except the soft-reset bit 7, read 0. cfg_ping_blk follows bit 4.
- R3: In flat mode (bit 0 clear), a host access to any nonzero address A raises mem_we or mem_re in the same cycle, with mem_addr equal to A and mem_wdata equal to host_wdata. mem_we and mem_re are never high together.
- R4: In windowed mode only host_addr[1:0] is decoded. Offset 1 holds pointer bits 14:8, taken from write data bits 6:0 and read back with bit 7 as 0. Offset 2 holds pointer bits 7:0. A pointer access produces no internal strobe.
- R5: In windowed mode an access to offset 3 is sent to the internal space at the current pointer value.
- R6: When stepping (bit 1) is set, every data port read or write advances the pointer by one from the next cycle. When it is clear, the pointer does not change.
- R7: The pointer is 15 bits wide and steps from 0x7FFF to 0x0000.
- R8: Writing the control register with bit 7 set clears bits 0, 1 and 4 and the pointer. Bit 7 then reads 1 for exactly RST_CYCLES cycles, starting the cycle after the write, and 0 after that.
- R9: While the soft reset is in progress, host writes are dropped, no internal strobe is raised, and reads of any location other than the control register return 0x00.
- R10: host_rvalid is high in the cycle after each read request, and low after a write or an idle cycle. host_rdata carries the value read.
- R11: With stepping on, two back-to-back data port writes put the first byte at the pointer and the second at pointer + 1. This is the big-endian, high-byte-first order of 16-bit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | One-cycle host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |
| mem_addr | output | ADDR_W | Internal address |
| mem_wdata | output | 8 | Internal write byte |
| mem_we | output | 1 | Internal write strobe |
| mem_re | output | 1 | Internal read strobe |
| mem_rdata | input | 8 | Internal read byte, valid in the same cycle as mem_re |
| cfg_ping_blk | output | 1 | Ping-block flag from control bit 4 |

## Verification
The assertions assume the following about the inputs. At most one host access happens per cycle. Each request lasts one cycle. mem_rdata settles combinationally from mem_addr within the cycle. No other agent changes the pointer. The bench drives every request at the falling edge and holds it for exactly one cycle. It returns internal read data from its own sparse memory once the strobes have settled. The soft-reset bit is kept out of the random control writes, so the reference model only has to follow the busy window in the dedicated directed sequence.

// File: rtl/hwb_pkg.sv
package hwb_pkg;

    // host offsets decoded in windowed mode
    localparam logic [1:0] OFF_CTRL = 2'd0;
    localparam logic [1:0] OFF_PHI  = 2'd1;
    localparam logic [1:0] OFF_PLO  = 2'd2;
    localparam logic [1:0] OFF_DATA = 2'd3;

    // control register bit positions
    localparam int CB_IND  = 0;
    localparam int CB_STEP = 1;
    localparam int CB_PING = 4;
    localparam int CB_SRST = 7;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_PHI,
        SEL_PLO,
        SEL_MEM
    } sel_e;

    typedef struct packed {
        logic ping;
        logic step;
        logic ind;
    } ctrl_t;

endpackage

// File: rtl/hwb_decode.sv
module hwb_decode
    import hwb_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ind,
    input  logic              busy,
    output sel_e              sel
);
    sel_e raw;

    always_comb begin
        raw = SEL_NONE;
        if (req) begin
            if (ind) begin
                case (addr[1:0])
                    OFF_CTRL: raw = SEL_CTRL;
                    OFF_PHI:  raw = SEL_PHI;
                    OFF_PLO:  raw = SEL_PLO;
                    default:  raw = SEL_MEM;
                endcase
            end else if (addr == '0) begin
                raw = SEL_CTRL;
            end else begin
                raw = SEL_MEM;
            end
        end
    end

    // soft reset: only reads of the control register survive
    always_comb begin
        sel = raw;
        if (busy) begin
            if (we || raw != SEL_CTRL) begin
                sel = SEL_NONE;
            end
        end
    end

endmodule

// File: rtl/hwb_ctrl_reg.sv
module hwb_ctrl_reg
    import hwb_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  logic  wr_srst,
    input  logic  wr_ping,
    input  logic  wr_step,
    input  logic  wr_ind,
    output ctrl_t ctrl,
    output logic  busy,
    output logic  clr
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        clr  = 1'b0;
        if (wr_en) begin
            if (wr_srst) begin
                st_d.ctrl = '0;
                st_d.cnt  = CNT_W'(RST_CYCLES);
                clr       = 1'b1;
            end else begin
                st_d.ctrl.ind  = wr_ind;
                st_d.ctrl.step = wr_step;
                st_d.ctrl.ping = wr_ping;
            end
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl = st_q.ctrl;
    assign busy = (st_q.cnt != '0);

endmodule

// File: rtl/hwb_pointer.sv
module hwb_pointer #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic              step,
    input  logic [7:0]        wdata,
    output logic [ADDR_W-1:0] ptr
);
    localparam int HI_W = ADDR_W - 8;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.ptr = '0;
        end else if (wr_hi) begin
            st_d.ptr[ADDR_W-1:8] = wdata[HI_W-1:0];
        end else if (wr_lo) begin
            st_d.ptr[7:0] = wdata;
        end else if (step) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.ptr;

endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
    import hwb_pkg::*;
#(
    parameter int          ADDR_W     = 15,
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              host_rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata,
    output logic              cfg_ping_blk
);
    localparam int HI_W  = ADDR_W - 8;
    localparam int PAD_W = 8 - HI_W;

    typedef struct packed {
        logic [7:0] rdata;
        logic       rvalid;
    } rsp_t;

    sel_e              sel;
    ctrl_t             ctrl;
    logic              busy;
    logic              clr;
    logic              mode_ind;
    logic              mode_step;
    logic [ADDR_W-1:0] ptr_val;
    logic              mem_hit;
    logic [7:0]        rd_mux;
    rsp_t              rsp_d, rsp_q;

    assign mode_ind  = ctrl.ind;
    assign mode_step = ctrl.step;

    hwb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req  (host_req),
        .we   (host_we),
        .addr (host_addr),
        .ind  (mode_ind),
        .busy (busy),
        .sel  (sel)
    );

    hwb_ctrl_reg #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sel == SEL_CTRL && host_we),
        .wr_srst (host_wdata[CB_SRST]),
        .wr_ping (host_wdata[CB_PING]),
        .wr_step (host_wdata[CB_STEP]),
        .wr_ind  (host_wdata[CB_IND]),
        .ctrl    (ctrl),
        .busy    (busy),
        .clr     (clr)
    );

    hwb_pointer #(.ADDR_W(ADDR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .wr_hi (sel == SEL_PHI && host_we),
        .wr_lo (sel == SEL_PLO && host_we),
        .step  (mem_hit && mode_ind && mode_step),
        .wdata (host_wdata),
        .ptr   (ptr_val)
    );

    // internal port
    always_comb begin
        mem_hit   = (sel == SEL_MEM);
        mem_addr  = mode_ind ? ptr_val : host_addr;
        mem_wdata = host_wdata;
        mem_we    = mem_hit && host_we;
        mem_re    = mem_hit && !host_we;
    end

    // read mux and response register
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_CTRL: begin
                rd_mux[CB_SRST] = busy;
                rd_mux[CB_PING] = ctrl.ping;
                rd_mux[CB_STEP] = ctrl.step;
                rd_mux[CB_IND]  = ctrl.ind;
            end
            SEL_PHI:  rd_mux = {{PAD_W{1'b0}}, ptr_val[ADDR_W-1:8]};
            SEL_PLO:  rd_mux = ptr_val[7:0];
            SEL_MEM:  rd_mux = mem_rdata;
            default:  rd_mux = '0;
        endcase
        rsp_d        = rsp_q;
        rsp_d.rvalid = host_req && !host_we;
        if (rsp_d.rvalid) begin
            rsp_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign host_rdata   = rsp_q.rdata;
    assign host_rvalid  = rsp_q.rvalid;
    assign cfg_ping_blk = ctrl.ping;

endmodule

// File: rtl/hwb_checker.sv
module hwb_checker #(
    parameter int          ADDR_W     = 15,
    parameter int unsigned RST_CYCLES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_rvalid,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              mode_ind,
    input logic              mode_step,
    input logic [ADDR_W-1:0] ptr_val
);
    int unsigned busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len <= 0;
        end else if (busy) begin
            busy_len <= busy_len + 1;
        end else begin
            busy_len <= 0;
        end
    end

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_flat_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && !mode_ind) |-> (mem_addr == host_addr));

    assert_port_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && mode_ind) |-> (mem_addr == ptr_val));

    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && mode_ind && mode_step) |=>
            (ptr_val == ADDR_W'($past(ptr_val) + 1'b1)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && mode_ind && !mode_step) |=> $stable(ptr_val));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!mode_ind && !mode_step && ptr_val == '0));

    assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == RST_CYCLES));

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!mem_we && !mem_re));

    assert_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_we) |=> host_rvalid);

    assert_no_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_req && !host_we) |=> !host_rvalid);

endmodule

bind regwin_bridge hwb_checker #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_rvalid (host_rvalid),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .mem_addr    (mem_addr),
    .busy        (busy),
    .mode_ind    (mode_ind),
    .mode_step   (mode_step),
    .ptr_val     (ptr_val)
);

// File: tb/regwin_bridge_test.sv
`timescale 1ns/1ps
module regwin_bridge_test;
    localparam int AW = 15;
    localparam int NRST = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic [7:0]    host_rdata;
    logic          host_rvalid;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_we;
    logic          mem_re;
    logic [7:0]    mem_rdata = '0;
    logic          cfg_ping_blk;

    int checks = 0;
    int errors = 0;

    logic [7:0] dut_mem [int unsigned];
    logic [7:0] exp_mem [int unsigned];
    bit         e_ind, e_step, e_ping;
    logic [AW-1:0] e_ptr;

    always #2.5 clk = ~clk;

    regwin_bridge #(.ADDR_W(AW), .RST_CYCLES(NRST)) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .cfg_ping_blk(cfg_ping_blk)
    );

    function automatic logic [7:0] dflt(input logic [AW-1:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, got, exp);
        end
    endtask

    // one host access, called at a falling edge, returns at the next one
    task automatic bus(input bit we, input logic [AW-1:0] a, input logic [7:0] wd,
                       output logic [7:0] rd, output logic rv, output logic mw,
                       output logic mr, output logic [AW-1:0] ma, output logic [7:0] mwd);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd;
        #1;
        mw = mem_we; mr = mem_re; ma = mem_addr; mwd = mem_wdata;
        mem_rdata = dut_mem.exists(ma) ? dut_mem[ma] : dflt(ma);
        if (mw) dut_mem[ma] = mwd;
        @(negedge clk);
        rd = host_rdata; rv = host_rvalid;
        host_req = 1'b0; host_we = 1'b0;
    endtask

    // reference model of one access outside soft reset
    task automatic model(input bit we, input logic [AW-1:0] a, input logic [7:0] wd,
                         output bit emw, output bit emr, output logic [AW-1:0] ema,
                         output logic [7:0] erd);
        emw = 0; emr = 0; ema = '0; erd = '0;
        if ((!e_ind && a == '0) || (e_ind && a[1:0] == 2'd0)) begin
            if (we) begin e_ind = wd[0]; e_step = wd[1]; e_ping = wd[4]; end
            else erd = {3'b0, e_ping, 2'b0, e_step, e_ind};
        end else if (!e_ind) begin
            ema = a;
            if (we) begin emw = 1; exp_mem[a] = wd; end
            else begin emr = 1; erd = exp_mem.exists(a) ? exp_mem[a] : dflt(a); end
        end else if (a[1:0] == 2'd1) begin
            if (we) e_ptr[14:8] = wd[6:0]; else erd = {1'b0, e_ptr[14:8]};
        end else if (a[1:0] == 2'd2) begin
            if (we) e_ptr[7:0] = wd; else erd = e_ptr[7:0];
        end else begin
            ema = e_ptr;
            if (we) begin emw = 1; exp_mem[e_ptr] = wd; end
            else begin emr = 1; erd = exp_mem.exists(e_ptr) ? exp_mem[e_ptr] : dflt(e_ptr); end
            if (e_step) e_ptr = e_ptr + 1'b1;
        end
    endtask

    task automatic op(input string req, input bit we, input logic [AW-1:0] a,
                      input logic [7:0] wd);
        bit emw, emr; logic [AW-1:0] ema; logic [7:0] erd;
        logic [7:0] rd, mwd; logic rv, mw, mr; logic [AW-1:0] ma;
        model(we, a, wd, emw, emr, ema, erd);
        bus(we, a, wd, rd, rv, mw, mr, ma, mwd);
        chk({req, " strobes"}, {mw, mr}, {emw, emr});
        if (emw || emr) chk({req, " mem_addr"}, ma, ema);
        if (emw) chk({req, " mem_wdata"}, mwd, wd);
        chk("R10 rvalid", rv, !we);
        if (!we) chk({req, " rdata"}, rd, erd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] rd, mwd; logic rv, mw, mr; logic [AW-1:0] ma;
        void'($urandom(32'd20240611));
        e_ind = 0; e_step = 0; e_ping = 0; e_ptr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ping", cfg_ping_blk, 1'b0);
        op("R1 ctrl", 0, 15'h0000, 8'h00);
        op("R2 ctrl write", 1, 15'h0000, 8'h7E);
        op("R2 ctrl masked", 0, 15'h0000, 8'h00);
        chk("R2 ping out", cfg_ping_blk, 1'b1);
        op("R2 ctrl clear", 1, 15'h0000, 8'h00);

        // R3 flat mode
        op("R3 write", 1, 15'h0003, 8'hC3);
        op("R3 write hi", 1, 15'h7FFF, 8'h3C);
        op("R3 read", 0, 15'h0003, 8'h00);
        op("R3 read hi", 0, 15'h7FFF, 8'h00);

        // R1 pointer reset value, R4 pointer bytes
        op("R2 to windowed", 1, 15'h0000, 8'h01);
        op("R1 ptr hi", 0, 15'h0001, 8'h00);
        op("R1 ptr lo", 0, 15'h0002, 8'h00);
        op("R4 ptr hi", 1, 15'h0001, 8'hFF);
        op("R4 ptr lo", 1, 15'h0002, 8'hFE);
        op("R4 ptr hi rd", 0, 15'h0001, 8'h00);
        op("R4 ptr lo rd", 0, 15'h0002, 8'h00);

        // R6 no stepping, R4 aliasing of upper address bits
        op("R6 hold", 1, 15'h1233, 8'h11);
        op("R4 alias", 0, 15'h7FF3, 8'h00);
        op("R6 hold lo", 0, 15'h0002, 8'h00);

        // R11 high byte first, R7 wrap
        op("R2 step on", 1, 15'h0004, 8'h03);
        op("R11 hi byte", 1, 15'h0003, 8'hAB);
        op("R11 lo byte", 1, 15'h0003, 8'hCD);
        op("R7 wrap hi", 0, 15'h0001, 8'h00);
        op("R7 wrap lo", 0, 15'h0002, 8'h00);
        op("R2 flat", 1, 15'h0000, 8'h00);
        op("R11 read hi", 0, 15'h7FFE, 8'h00);
        op("R11 read lo", 0, 15'h7FFF, 8'h00);

        // R8 / R9 soft reset
        op("R2 setup", 1, 15'h0000, 8'h13);
        op("R4 setup", 1, 15'h0002, 8'h05);
        bus(1, 15'h0000, 8'h93, rd, rv, mw, mr, ma, mwd);
        chk("R8 ping cleared", cfg_ping_blk, 1'b0);
        bus(1, 15'h0003, 8'h77, rd, rv, mw, mr, ma, mwd);
        chk("R9 write dropped", {mw, mr}, 2'b00);
        bus(0, 15'h0005, 8'h00, rd, rv, mw, mr, ma, mwd);
        chk("R9 read strobe", {mw, mr}, 2'b00);
        chk("R9 read zero", rd, 8'h00);
        chk("R10 rvalid busy", rv, 1'b1);
        for (int k = 3; k <= NRST + 1; k++) begin
            bus(0, 15'h0000, 8'h00, rd, rv, mw, mr, ma, mwd);
            chk("R8 busy bit", rd, (k <= NRST) ? 8'h80 : 8'h00);
        end
        e_ind = 0; e_step = 0; e_ping = 0; e_ptr = '0;
        op("R8 windowed", 1, 15'h0000, 8'h01);
        op("R8 ptr hi", 0, 15'h0001, 8'h00);
        op("R8 ptr lo", 0, 15'h0002, 8'h00);
        op("R9 mem kept", 0, 15'h0003, 8'h00);

        // random mix: R3 R4 R5 R6
        for (int i = 0; i < 1500; i++) begin
            int sel;
            logic [AW-1:0] a;
            logic [7:0] wd;
            bit we;
            sel = $urandom % 10;
            we  = $urandom % 2;
            wd  = $urandom;
            if (sel == 0) begin
                a = e_ind ? {13'($urandom), 2'd0} : '0;
                we = 1; wd = wd & 8'h7F;
            end else if (e_ind) begin
                if (sel < 3) begin
                    a = {13'($urandom), 2'd1};
                    if (we) wd = ($urandom % 4 == 0) ? wd : 8'h00;
                end else if (sel < 5) begin
                    a = {13'($urandom), 2'd2};
                    if (we) wd = wd % 8'd40;
                end else a = {13'($urandom), 2'd3};
            end else begin
                a = AW'(1 + $urandom % 40);
            end
            op(e_ind ? "R5 R6 random" : "R3 random", we, a, wd);
        end

        summary();
    end

endmodule